// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block takes 16-bit control words from a three-wire serial port made of a control clock, a data line and a latch line, and writes them into four configuration registers: left volume, right volume, converter control and clock-generator control. The serial port may run at up to 8 MHz with no phase relation to the system clock. All three serial lines are brought into the system clock domain through two-flop synchronisers, and their edges are detected there.

A host pulls the latch line low, sends sixteen bits MSB first, and each bit is sampled on a rising control-clock edge. It then raises the latch line. On that rising latch edge the word is committed, but only if exactly sixteen clock edges were seen while the latch was low. The two least significant bits of the word select the target register. Every field is driven straight from a register, so downstream logic sees a whole word change in one system cycle. An active-low synchronous reset restores every default.

Top module: `ctlport_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both volumes go to 14'h3FFF (full volume), and every converter-control field and `pll_cfg` go to zero.
- R2: A word is sampled MSB first, one bit per rising `ser_clk` edge while `ser_lat` is low. It is committed on the rising edge of `ser_lat`, and the outputs reflect it within 12 system clocks of that edge.
- R3: Address bits [1:0] = 2'b00 write word bits [15:2] to `vol_left`. Address bits 2'b10 write word bits [15:2] to `vol_right`.
- R4: Address 2'b01 writes the converter control: [11:10] to `interp_sel` (00 8x, 01 4x, 10 2x), [9:8] to `word_len` (00 24 bits, 01 20 bits, 10/11 16 bits), [7] to `phase_inv`, [6] to `soft_mute`, [5:4] to `fmt_sel` (00 I2S, 01 right-justified, 10 DSP, 11 left-justified) and [3:2] to `deemph_sel` (00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz). Bits [15:12] are ignored.
- R5: Address 2'b11 writes word bits [11:2] to `pll_cfg`. Bits [15:12] are ignored.
- R6: A frame with fewer or more than 16 rising clock edges while the latch is low is discarded, and no output changes.
- R7: Rising `ser_clk` edges while `ser_lat` is high neither write a register nor count toward the next frame. A gated clock that idles low between frames is accepted.
- R8: A committed word changes only the addressed register. All other outputs hold their values.
- R9: A rising `ser_clk` edge that reaches the system domain in the same cycle as the rising latch edge counts as the last bit of the frame.
- R10: Reset asserted in the middle of a frame aborts it. The remainder of that frame, once its latch rises, writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial control clock (asynchronous) |
| ser_dat | input | 1 | Serial control data, MSB first |
| ser_lat | input | 1 | Latch line, low during a frame |
| vol_left | output | 14 | Left volume, unsigned |
| vol_right | output | 14 | Right volume, unsigned |
| interp_sel | output | 2 | Interpolation factor code |
| word_len | output | 2 | Audio word length code |
| phase_inv | output | 1 | Output phase inversion |
| soft_mute | output | 1 | Soft mute request |
| fmt_sel | output | 2 | Serial audio format code |
| deemph_sel | output | 2 | De-emphasis filter code |
| pll_cfg | output | 10 | Clock-generator control field |

## Verification
The two functions that can fall in the same system cycle are counting the last data bit and committing on the latch rising edge. The last clock edge and the latch edge pass through identical synchronisers. The bench therefore raises `ser_clk` and `ser_lat` at the same instant after fifteen ordinary bits. The frame is judged correct only if the word lands in its register as a full sixteen-bit frame. A second collision, a reset arriving in the middle of a frame, is judged by checking that the later latch rise writes nothing.

// File: rtl/ctlport_pkg.sv
`timescale 1ns/1ps
package ctlport_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 2;
  localparam int VOL_W  = 14;
  localparam int CFG_W  = 10;

  typedef enum logic [1:0] {
    A_VOL_L = 2'b00,
    A_DAC   = 2'b01,
    A_VOL_R = 2'b10,
    A_PLL   = 2'b11
  } reg_addr_e;

  // Field order matches word bits [11:2]
  typedef struct packed {
    logic [1:0] interp;
    logic [1:0] width;
    logic       phase;
    logic       mute;
    logic [1:0] fmt;
    logic [1:0] deemph;
  } dac_cfg_t;
endpackage

// File: rtl/ctlport_sync.sv
`timescale 1ns/1ps
module ctlport_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev,
  output logic rise,
  output logic fall
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign lvl  = chain[STAGES-1];
  assign prev = chain[STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/ctlport_deser.sv
`timescale 1ns/1ps
module ctlport_deser #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              dat_lvl,
  input  logic              lat_prev,
  input  logic              lat_rise,
  input  logic              lat_fall,
  output logic              wr_vld,
  output logic [WORD_W-1:0] wr_word
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_SAT = WORD_W + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              take;

  // A bit belongs to the frame when the latch was low in the previous cycle,
  // so an edge coinciding with the latch rise still counts.
  assign take = sck_rise & ~lat_prev;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (take) begin
      sh_n = {sh_q[WORD_W-2:0], dat_lvl};
      if (cnt_q != CNT_W'(CNT_SAT)) cnt_n = cnt_q + 1'b1;
    end
    if (lat_fall) cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      wr_vld  <= 1'b0;
      wr_word <= '0;
    end else begin
      sh_q   <= sh_n;
      wr_vld <= 1'b0;
      if (lat_rise) begin
        wr_vld  <= (cnt_n == CNT_W'(WORD_W));
        wr_word <= sh_n;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_n;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_SAT)); // R6
  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lat_fall |=> (cnt_q == '0)); // R7
  AST_WRITE_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> lat_prev); // R2
endmodule

// File: rtl/ctlport_regs.sv
`timescale 1ns/1ps
module ctlport_regs
  import ctlport_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VOL_W  = 14,
  parameter int CFG_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [WORD_W-1:0] wr_word,
  output logic [VOL_W-1:0]  vol_l,
  output logic [VOL_W-1:0]  vol_r,
  output dac_cfg_t          dac,
  output logic [CFG_W-1:0]  pll
);
  localparam int CFG_HI = CFG_W + 1;

  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_word[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_l <= '1;
      vol_r <= '1;
      dac   <= '0;
      pll   <= '0;
    end else if (wr_vld) begin
      unique case (addr)
        A_VOL_L: vol_l <= wr_word[WORD_W-1:2];
        A_VOL_R: vol_r <= wr_word[WORD_W-1:2];
        A_DAC:   dac   <= dac_cfg_t'(wr_word[CFG_HI:2]);
        A_PLL:   pll   <= wr_word[CFG_HI:2];
        default: ;
      endcase
    end
  end

  AST_VOLL_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_l) |-> $past(wr_vld && wr_word[1:0] == 2'b00)); // R8
  AST_VOLR_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_r) |-> $past(wr_vld && wr_word[1:0] == 2'b10)); // R3
  AST_DAC_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac) |-> $past(wr_vld && wr_word[1:0] == 2'b01)); // R4
  AST_PLL_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll) |-> $past(wr_vld && wr_word[1:0] == 2'b11)); // R5
endmodule

// File: rtl/ctlport_top.sv
`timescale 1ns/1ps
module ctlport_top
  import ctlport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_lat,
  output logic [VOL_W-1:0] vol_left,
  output logic [VOL_W-1:0] vol_right,
  output logic [1:0]       interp_sel,
  output logic [1:0]       word_len,
  output logic             phase_inv,
  output logic             soft_mute,
  output logic [1:0]       fmt_sel,
  output logic [1:0]       deemph_sel,
  output logic [CFG_W-1:0] pll_cfg
);
  localparam int N_LINES = 3;          // 0 clock, 1 data, 2 latch
  localparam logic [N_LINES-1:0] IDLE = 3'b100;

  logic [N_LINES-1:0] raw, lvl, prev, rise, fall;
  assign raw = {ser_lat, ser_dat, ser_clk};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    ctlport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE[g])) u_sync (
      .clk (clk), .rst_n(rst_n), .din(raw[g]),
      .lvl (lvl[g]), .prev(prev[g]), .rise(rise[g]), .fall(fall[g])
    );
  end

  logic              wr_vld;
  logic [WORD_W-1:0] wr_word;
  dac_cfg_t          dac;

  ctlport_deser #(.WORD_W(WORD_W)) u_deser (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_rise(rise[0]),
    .dat_lvl (lvl[1]),
    .lat_prev(prev[2]),
    .lat_rise(rise[2]),
    .lat_fall(fall[2]),
    .wr_vld  (wr_vld),
    .wr_word (wr_word)
  );

  ctlport_regs #(.WORD_W(WORD_W), .VOL_W(VOL_W), .CFG_W(CFG_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_vld (wr_vld),
    .wr_word(wr_word),
    .vol_l  (vol_left),
    .vol_r  (vol_right),
    .dac    (dac),
    .pll    (pll_cfg)
  );

  assign interp_sel = dac.interp;
  assign word_len   = dac.width;
  assign phase_inv  = dac.phase;
  assign soft_mute  = dac.mute;
  assign fmt_sel    = dac.fmt;
  assign deemph_sel = dac.deemph;

  AST_RESET_DEFAULT: assert property (@(posedge clk)
    !rst_n |=> (vol_left == '1 && vol_right == '1 && pll_cfg == '0)); // R1
endmodule

// File: tb/tb_ctlport_top.sv
`timescale 1ns/1ps
module tb_ctlport_top;
  localparam time CLK_HALF = 2ns;
  localparam time HALF     = 32ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b1;
  logic [13:0] vol_left, vol_right;
  logic [1:0]  interp_sel, word_len, fmt_sel, deemph_sel;
  logic        phase_inv, soft_mute;
  logic [9:0]  pll_cfg;

  int total = 0, bad = 0;
  bit done = 0;
  logic [13:0] m_vl, m_vr;
  logic [9:0]  m_dac, m_pll;

  always #CLK_HALF clk = ~clk;

  ctlport_top dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .vol_left(vol_left), .vol_right(vol_right),
    .interp_sel(interp_sel), .word_len(word_len), .phase_inv(phase_inv),
    .soft_mute(soft_mute), .fmt_sel(fmt_sel), .deemph_sel(deemph_sel),
    .pll_cfg(pll_cfg)
  );

  function automatic logic [47:0] snap();
    return {vol_left, vol_right, interp_sel, word_len, phase_inv, soft_mute,
            fmt_sel, deemph_sel, pll_cfg};
  endfunction

  function automatic logic [47:0] model();
    return {m_vl, m_vr, m_dac, m_pll};
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_vl = 14'h3FFF; m_vr = 14'h3FFF; m_dac = '0; m_pll = '0;
  endtask

  task automatic model_commit(input logic [15:0] w);
    case (w[1:0])
      2'b00: m_vl  = w[15:2];
      2'b10: m_vr  = w[15:2];
      2'b01: m_dac = w[11:2];
      2'b11: m_pll = w[11:2];
    endcase
  endtask

  // Send the n low bits of v, MSB first, framed by the latch
  task automatic send_bits(input logic [31:0] v, input int n);
    ser_lat = 1'b0; #HALF;
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i]; #HALF;
      ser_clk = 1'b1; #HALF;
      ser_clk = 1'b0;
    end
    #HALF; ser_lat = 1'b1;
    #(2*HALF);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset defaults", snap(), {14'h3FFF, 14'h3FFF, 10'h000, 10'h000});
  endtask

  task automatic t_volumes();
    send_bits(32'h48D0, 16); model_commit(16'h48D0);
    check("R2 R3 left volume", snap(), model());
    check("R3 left value", {34'd0, vol_left}, {34'd0, 14'h1234});
    send_bits(32'h2AF2, 16); model_commit(16'h2AF2);
    check("R3 right volume", snap(), model());
  endtask

  task automatic t_dac();
    send_bits(32'hF9ED, 16); model_commit(16'hF9ED);
    check("R4 dac fields", {36'd0, interp_sel, word_len, phase_inv, soft_mute, fmt_sel, deemph_sel},
          {36'd0, 2'd2, 2'd1, 1'b1, 1'b1, 2'd2, 2'd3});
    check("R4 R8 dac snapshot", snap(), model());
    send_bits(32'h0225, 16); model_commit(16'h0225);
    check("R4 width 16 deemph 44k", {44'd0, word_len, deemph_sel}, {44'd0, 2'd2, 2'd1});
  endtask

  task automatic t_pll();
    send_bits(32'hA5A7, 16); model_commit(16'hA5A7);
    check("R5 pll field", {38'd0, pll_cfg}, {38'd0, 10'h169});
    check("R5 R8 snapshot", snap(), model());
  endtask

  task automatic t_bad_len();
    send_bits(32'h7FFC, 15);
    check("R6 short frame dropped", snap(), model());
    send_bits(32'h0_0004, 17);
    check("R6 long frame dropped", snap(), model());
  endtask

  task automatic t_idle_clocks();
    ser_dat = 1'b1;
    for (int i = 0; i < 20; i++) begin
      #HALF; ser_clk = 1'b1; #HALF; ser_clk = 1'b0;
    end
    #HALF; @(negedge clk);
    check("R7 clocks with latch high", snap(), model());
    send_bits(32'h0010, 16); model_commit(16'h0010);
    check("R7 gated frame after idle clocks", snap(), model());
  endtask

  task automatic t_coincide();
    logic [15:0] w = 16'h0008;
    ser_lat = 1'b0; #HALF;
    for (int i = 15; i >= 1; i--) begin
      ser_dat = w[i]; #HALF; ser_clk = 1'b1; #HALF; ser_clk = 1'b0;
    end
    ser_dat = w[0]; #HALF;
    ser_clk = 1'b1; ser_lat = 1'b1;
    #HALF; ser_clk = 1'b0; #(2*HALF);
    @(negedge clk);
    model_commit(w);
    check("R9 edge with latch rise counted", snap(), model());
  endtask

  task automatic t_sequence();
    send_bits(32'h0004, 16); model_commit(16'h0004);
    check("R8 left only", snap(), model());
    send_bits(32'hFFFE, 16); model_commit(16'hFFFE);
    check("R8 right only", snap(), model());
  endtask

  task automatic t_reset_midframe();
    ser_lat = 1'b0; #HALF;
    for (int i = 0; i < 8; i++) begin
      ser_dat = i[0]; #HALF; ser_clk = 1'b1; #HALF; ser_clk = 1'b0;
    end
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < 8; i++) begin
      ser_dat = 1'b1; #HALF; ser_clk = 1'b1; #HALF; ser_clk = 1'b0;
    end
    #HALF; ser_lat = 1'b1; #(2*HALF); @(negedge clk);
    check("R10 aborted frame writes nothing", snap(), model());
    send_bits(32'h0101, 16); model_commit(16'h0101);
    check("R10 next frame accepted", snap(), model());
  endtask

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_volumes();
    t_dac();
    t_pll();
    t_bad_len();
    t_idle_clocks();
    t_coincide();
    t_sequence();
    t_reset_midframe();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule